// File: doc/BRIEF.md
# Three-State Phase-Frequency Detector with Lock Indication

This block compares the rising edges of a reference clock input and a divided oscillator input. Both inputs are sampled by a fast system clock. The block reports the timing error in two forms at once. The first is a single-ended error signal that can drive high, drive low or float. It is modelled as a drive enable plus a level, so that a pad wrapper can build the tristate. The second is a pair of active-low pulse rails for an external differential combiner. A lock output is derived from the same internal state.

Internally, a rising reference edge raises an "up" flag and a rising oscillator edge raises a "down" flag. When both flags are raised, they stay raised together for a programmable minimum width and then clear. This produces a short pulse on both rails at the same time when the loop is in phase. The dividers, the prescaler and the analogue loop filter sit outside this block.

Top module: `pfd_lock_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge both rails read 1, `err_oe` reads 0 and `lock_o` reads 1. This holds even when the detector was mid-error.
- R2: A reference rising edge with no oscillator edge pending gives the "up" state. In the "up" state `err_oe`=1, `err_lvl`=1, `rail_ref_n`=0, `rail_vco_n`=1 and `lock_o`=0.
- R3: An oscillator rising edge with no reference edge pending gives the "down" state. In the "down" state `err_oe`=1, `err_lvl`=0, `rail_ref_n`=1, `rail_vco_n`=0 and `lock_o`=0.
- R4: Once both flags are raised, both rails read 0, `err_oe` reads 0 and `lock_o` reads 1. This lasts for exactly `MIN_PW` clock cycles, after which the block returns to idle (rails 1, `err_oe` 0).
- R5: Rising edges on both inputs in the same sample give only the coincident pulse of R4. `err_oe` never rises.
- R6: Only rising edges act. An input held high or falling leaves the outputs unchanged.
- R7: Inputs pass a `SYNC_STAGES` flop synchroniser. With the default of 2, an input rise first set up before clock edge k shows on the outputs after edge k+2.
- R8: A second rising edge on the same input while its flag is already raised keeps the block in the same single-flag state.
- R9: `lock_o` is 0 exactly when one flag alone is raised, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference clock input, asynchronous |
| vco_in | input | 1 | Divided oscillator input, asynchronous |
| err_oe | output | 1 | Drive enable of the single-ended error output |
| err_lvl | output | 1 | Level driven when `err_oe` is 1 |
| rail_ref_n | output | 1 | Active-low rail, pulses when the reference leads |
| rail_vco_n | output | 1 | Active-low rail, pulses when the oscillator leads |
| lock_o | output | 1 | High in lock, pulses low while out of lock |

## Verification
The embedded assertions check several properties on every cycle:
- A detected edge always raises its flag on the next cycle.
- The both-raised window never reaches `MIN_PW` counts and always releases on time.
- A detected edge never lasts two cycles.
- Reset always clears the flags.
- A driven single-ended output always comes with exactly one rail low.

Only the bench scenarios can show the rest:
- the synchroniser latency;
- the ordering cases (reference first, oscillator first, simultaneous);
- that held and falling inputs are ignored;
- that repeated edges keep a single-flag state.

// File: rtl/pfd_pkg.sv
// Package pfd_pkg
// Purpose : shared state encoding for the phase-frequency detector.
// Assumes : nothing; pure type definitions.
package pfd_pkg;

    // Detector condition derived from the two internal flags
    typedef enum logic [1:0] {
        PFD_IDLE = 2'b00,
        PFD_UP   = 2'b01,
        PFD_DOWN = 2'b10,
        PFD_BOTH = 2'b11
    } pfd_cond_e;

    // Map the flag pair onto the condition encoding
    function automatic pfd_cond_e pfd_cond(input logic up, input logic dn);
        return pfd_cond_e'({dn, up});
    endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
// Module pfd_edge_sync
// Purpose : brings one asynchronous input into the clk domain through a
//           flop chain and flags its rising edges as one-cycle strobes.
// Assumes : input high and low phases each last at least one clk period;
//           STAGES >= 2.
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Synchroniser chain: stage 0 samples the raw input
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // History flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    // Rising edge strobe
    assign rise_o = chain_q[STAGES-1] & ~last_q;

    // R6: a detected rising edge is never two cycles long
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pfd_flags.sv
// Module pfd_flags
// Purpose : holds the up/down flags, and times the coincident window in
//           which both flags are raised.
// Assumes : strobes are one cycle wide; MIN_PW >= 1.
module pfd_flags #(
    parameter int MIN_PW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_up,
    input  logic set_dn,
    output logic up_o,
    output logic dn_o
);

    localparam int CW = (MIN_PW < 2) ? 1 : $clog2(MIN_PW);

    logic          up_q, dn_q;
    logic [CW-1:0] cnt_q;
    logic          both, done;

    assign both = up_q & dn_q;
    assign done = both && (cnt_q == CW'(MIN_PW - 1));

    // Flag registers: a new edge sets its flag, end of window clears both
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= (up_q & ~done) | set_up;
            dn_q <= (dn_q & ~done) | set_dn;
        end
    end

    // Window counter: runs only while both flags are raised
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (both && !done)  cnt_q <= cnt_q + 1'b1;
        else                     cnt_q <= '0;
    end

    assign up_o = up_q;
    assign dn_o = dn_q;

    // R2: a reference edge always raises up
    a_r2_up_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_up |=> up_q);
    // R3: an oscillator edge always raises down
    a_r3_dn_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_dn |=> dn_q);
    // R4: the coincident window never reaches MIN_PW counts
    a_r4_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        both |-> (int'(cnt_q) < MIN_PW));
    // R4: the last cycle of the window releases both flags
    a_r4_window_release: assert property (@(posedge clk) disable iff (!rst_n)
        (both && int'(cnt_q) == MIN_PW - 1 && !set_up && !set_dn) |=> (!up_q && !dn_q));
    // R1: reset clears both flags
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!up_q && !dn_q));

endmodule

// File: rtl/pfd_drive.sv
// Module pfd_drive
// Purpose : turns the flag pair into the tristate error signal, the
//           active-low rails and the lock output.
// Assumes : flags come straight from registers (glitch-free outputs).
module pfd_drive
    import pfd_pkg::*;
(
    input  logic up_i,
    input  logic dn_i,
    output logic err_oe,
    output logic err_lvl,
    output logic rail_ref_n,
    output logic rail_vco_n,
    output logic lock_o
);

    pfd_cond_e cond;

    // Decode the condition into all outputs
    always_comb begin
        cond       = pfd_cond(up_i, dn_i);
        err_oe     = 1'b0;
        err_lvl    = 1'b0;
        rail_ref_n = 1'b1;
        rail_vco_n = 1'b1;
        lock_o     = 1'b1;
        unique case (cond)
            PFD_UP: begin
                err_oe     = 1'b1;
                err_lvl    = 1'b1;
                rail_ref_n = 1'b0;
                lock_o     = 1'b0;
            end
            PFD_DOWN: begin
                err_oe     = 1'b1;
                rail_vco_n = 1'b0;
                lock_o     = 1'b0;
            end
            PFD_BOTH: begin
                rail_ref_n = 1'b0;
                rail_vco_n = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pfd_lock_top.sv
// Module pfd_lock_top
// Purpose : phase-frequency detector with tristate and dual-rail error
//           outputs and a lock indication.
// Assumes : ref_in and vco_in are slower than clk/2 with both phases wider
//           than one clk period; reset is synchronous, active low.
module pfd_lock_top #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_PW      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic vco_in,
    output logic err_oe,
    output logic err_lvl,
    output logic rail_ref_n,
    output logic rail_vco_n,
    output logic lock_o
);

    logic ref_rise, vco_rise;
    logic up, dn;

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ref_in), .rise_o(ref_rise)
    );

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_vco_sync (
        .clk(clk), .rst_n(rst_n), .async_in(vco_in), .rise_o(vco_rise)
    );

    pfd_flags #(.MIN_PW(MIN_PW)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_up(ref_rise), .set_dn(vco_rise),
        .up_o(up), .dn_o(dn)
    );

    pfd_drive u_drive (
        .up_i(up), .dn_i(dn),
        .err_oe(err_oe), .err_lvl(err_lvl),
        .rail_ref_n(rail_ref_n), .rail_vco_n(rail_vco_n),
        .lock_o(lock_o)
    );

    // R9: a driven error output always coincides with exactly one rail low and lock low
    a_r9_single_rail: assert property (@(posedge clk) disable iff (!rst_n)
        err_oe |-> (rail_ref_n != rail_vco_n) && !lock_o);

endmodule

// File: tb/test_pfd_lock_top.sv
// Scoreboard bench: the driver applies inputs at the falling edge and queues
// the expected output condition, and the monitor compares just after each rise.
module test_pfd_lock_top;

    localparam int MIN_PW = 2;

    // Expected output conditions
    localparam int C_IDLE = 0;
    localparam int C_UP   = 1;
    localparam int C_DN   = 2;
    localparam int C_BOTH = 3;

    typedef struct {
        int    cond;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic vco_in = 1'b0;
    logic err_oe, err_lvl, rail_ref_n, rail_vco_n, lock_o;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    pfd_lock_top #(.SYNC_STAGES(2), .MIN_PW(MIN_PW)) i_pfd_lock_top (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .vco_in(vco_in),
        .err_oe(err_oe), .err_lvl(err_lvl),
        .rail_ref_n(rail_ref_n), .rail_vco_n(rail_vco_n), .lock_o(lock_o)
    );

    // One cycle: set inputs before the next rise, queue the condition seen after it
    task automatic step(input logic rst_v, input logic r, input logic v,
                        input int cond, input string req);
        exp_t e;
        @(negedge clk);
        rst_n  = rst_v;
        ref_in = r;
        vco_in = v;
        e.cond = cond;
        e.req  = req;
        q.push_back(e);
    endtask

    // Monitor: compare the outputs against the queued expectation
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            logic [4:0] act, expv;
            e = q.pop_front();
            case (e.cond)
                C_UP:    expv = 5'b1_1_0_1_0;
                C_DN:    expv = 5'b1_0_1_0_0;
                C_BOTH:  expv = 5'b0_0_0_0_1;
                default: expv = 5'b0_0_1_1_1;
            endcase
            act = {err_oe, err_lvl, rail_ref_n, rail_vco_n, lock_o};
            if (!expv[4]) act[3] = 1'b0;
            checks++;
            if (act !== expv) begin
                fails++;
                $display("FAIL %s: {oe,lvl,rail_ref_n,rail_vco_n,lock} actual=%b expected=%b",
                         e.req, act, expv);
            end
        end
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, C_IDLE, "R1");
        for (int i = 0; i < 2; i++) step(1'b1, 1'b0, 1'b0, C_IDLE, "R1");

        // R7/R2: reference rises, shown two edges later; R6: holding high has no effect
        step(1'b1, 1'b1, 1'b0, C_IDLE, "R7");
        step(1'b1, 1'b1, 1'b0, C_IDLE, "R7");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, C_UP, "R2");
        // R8: repeated reference edge keeps the up state
        step(1'b1, 1'b0, 1'b0, C_UP, "R8");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, C_UP, "R8");
        // R4: oscillator catches up, coincident window, then idle
        step(1'b1, 1'b1, 1'b1, C_UP, "R4");
        step(1'b1, 1'b1, 1'b1, C_UP, "R4");
        for (int i = 0; i < MIN_PW; i++) step(1'b1, 1'b1, 1'b1, C_BOTH, "R4");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, C_IDLE, "R4");
        // R6: falling inputs have no effect
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, C_IDLE, "R6");

        // R3: oscillator leads
        step(1'b1, 1'b0, 1'b1, C_IDLE, "R3");
        step(1'b1, 1'b0, 1'b1, C_IDLE, "R3");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, C_DN, "R3");
        // R9: lock low through the down state, restored after the window
        step(1'b1, 1'b1, 1'b1, C_DN, "R9");
        step(1'b1, 1'b1, 1'b1, C_DN, "R9");
        for (int i = 0; i < MIN_PW; i++) step(1'b1, 1'b1, 1'b1, C_BOTH, "R9");
        step(1'b1, 1'b0, 1'b0, C_IDLE, "R9");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, C_IDLE, "R9");

        // R5: simultaneous rises give only the coincident pulse
        step(1'b1, 1'b1, 1'b1, C_IDLE, "R5");
        step(1'b1, 1'b1, 1'b1, C_IDLE, "R5");
        for (int i = 0; i < MIN_PW; i++) step(1'b1, 1'b1, 1'b1, C_BOTH, "R5");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, C_IDLE, "R5");

        // R1: reset during an error state
        step(1'b1, 1'b1, 1'b0, C_IDLE, "R1");
        step(1'b1, 1'b1, 1'b0, C_IDLE, "R1");
        step(1'b1, 1'b1, 1'b0, C_UP, "R1");
        step(1'b0, 1'b0, 1'b0, C_IDLE, "R1");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, C_IDLE, "R1");

        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule